// File: doc/BRIEF.md
# Colour Standard Identification Sequencer

This block runs the search loop that finds which colour television standard is present on the incoming video. It steps through a fixed, cyclic list of candidates. Each candidate pairs a colour standard with a crystal: PAL, SECAM or NTSC, on either the reference crystal or the second crystal. For each candidate it counts the lines on which the matching per-line detector flag is set.

A candidate that gathers enough hits within its dwell window is locked. The lock is held until the flag goes missing for a run of lines. While no standard is locked the colour killer stays on.

The candidate list is pruned in two ways. A two-bit crystal-fit code removes candidates the fitted crystals cannot support. Host force controls can restrict the loop to the SECAM group or to the combined PAL/NTSC group, and can restrict the crystal choice. Neither one changes the order of the loop. The block drives the current standard, the crystal select and a filter band code, and it collects them with the killer state into a status word for readout. All state changes happen only on the single-cycle line strobe.

Top module: `colour_id_seq`

## Requirements
- R1: After reset the block is unlocked with the colour killer on, and the candidate is PAL on the reference crystal.
- R2: Standard codes are PAL=00, NTSC=01, SECAM=10. Band codes are 3.58 MHz=00, 4.28 MHz=01, 4.43 MHz=10. The crystal select is 0 for the reference crystal and 1 for the second crystal. statusWord is {colourKill, xtalSel, stdSel[1:0]}, with bit 3 as its most significant bit.
- R3: A candidate is held for 16 line strobes. It locks at its 16th strobe when its flag was set on at least 12 of those lines. With 11 or fewer hits the next allowed candidate is taken in cyclic order.
- R4: The cyclic candidate order is 0 PAL/reference, 1 SECAM/reference, 2 NTSC/reference, 3 PAL/second, 4 NTSC/second.
- R5: xtalCfg codes are 00 = 4.4 MHz reference plus 3.6 MHz second, 01 = two 3.6 MHz, 10 = single 4.4 MHz reference, 11 = single 3.6 MHz reference. SECAM is allowed only when the reference crystal is 4.4 MHz (xtalCfg[0]=0).
- R6: With a single crystal fitted (xtalCfg[1]=1) the candidates on the second crystal are skipped, and after a strobe xtalSel is always 0.
- R7: forceGrp 01 allows only SECAM, 10 allows only PAL and NTSC, and 00 or 11 allows both groups. Excluded candidates are skipped like impossible ones.
- R8: forceXtal 01 allows only the reference crystal, 10 allows only the second crystal, and 00 or 11 allows either. If no candidate is allowed, the block idles on PAL/reference, unlocked.
- R9: SECAM is judged on secamLineFlag alone, PAL on palIdFlag and NTSC on ntscBurstFlag. PAL is tried before SECAM, so PAL wins when both flags are present.
- R10: A locked standard is released on the 8th consecutive line without its flag. The search then restarts at the first allowed candidate. A hit clears the miss run.
- R11: colourKill is 1 exactly when no standard is locked.
- R12: The band code is 4.28 MHz for SECAM. For PAL or NTSC it is 4.43 MHz on a 4.4 MHz reference crystal and 3.58 MHz otherwise, whichever crystal input is active.
- R13: A change of xtalCfg, forceGrp or forceXtal acts at the next line strobe. A lock that is no longer allowed is dropped there and the search restarts at the first allowed candidate. A disallowed search candidate moves to the next allowed one.
- R14: The detector flags and all state are ignored between line strobes. Flags seen without a strobe count for nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lineStb | input | 1 | One-cycle pulse per video line |
| palIdFlag | input | 1 | PAL line identification seen on this line |
| ntscBurstFlag | input | 1 | NTSC burst present on this line |
| secamLineFlag | input | 1 | SECAM line identification seen on this line |
| xtalCfg | input | 2 | Fitted crystal configuration |
| forceGrp | input | 2 | Host standard-group force |
| forceXtal | input | 2 | Host crystal force |
| stdSel | output | 2 | Current or locked standard |
| xtalSel | output | 1 | Crystal select, 0 = reference |
| bandSel | output | 2 | Filter band code |
| colourKill | output | 1 | Colour killer on |
| locked | output | 1 | A standard is locked |
| statusWord | output | 4 | Readout: killer, crystal, standard |

## Verification
All 64 combinations of crystal fit and force settings are run with the flags idle for several full passes of the loop. This shows the visit order of the surviving candidates, which candidates are skipped, and the fallback when none is allowed. Hit counts of 11 and 12 on a PAL dwell separate the acceptance threshold. Miss runs of 7 and 8 separate hold from release. Flags asserted without a strobe must leave the count untouched. PAL and SECAM flags together, and SECAM flags alone, separate PAL priority from SECAM acceptance. A force change made while SECAM is locked shows a lock being dropped at the next strobe.

// File: rtl/idseq_pkg.sv
package idseq_pkg;

  typedef enum logic [1:0] {
    STD_PAL   = 2'b00,
    STD_NTSC  = 2'b01,
    STD_SECAM = 2'b10
  } std_e;

  typedef enum logic {
    ST_SEARCH = 1'b0,
    ST_LOCKED = 1'b1
  } seqState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic clrCnt;
    logic countLine;
    logic stepNext;
    logic restart;
    logic trackMiss;
  } seqCmd_t;

  // datapath -> control conditions
  typedef struct packed {
    logic dwellEnd;
    logic enoughHits;
    logic lossEnd;
    logic curOk;
    logic anyOk;
  } seqStat_t;

  localparam int NCAND = 5;
  localparam int IDX_W = 3;

  localparam logic [1:0] GRP_SECAM   = 2'b01;
  localparam logic [1:0] GRP_PALNTSC = 2'b10;
  localparam logic [1:0] XF_REF      = 2'b01;
  localparam logic [1:0] XF_SECOND   = 2'b10;

  localparam logic [1:0] BAND_358 = 2'b00;
  localparam logic [1:0] BAND_428 = 2'b01;
  localparam logic [1:0] BAND_443 = 2'b10;

  function automatic std_e candStd(input logic [IDX_W-1:0] idx);
    case (idx)
      3'd0:    return STD_PAL;
      3'd1:    return STD_SECAM;
      3'd2:    return STD_NTSC;
      3'd3:    return STD_PAL;
      default: return STD_NTSC;
    endcase
  endfunction

  function automatic logic candSecond(input logic [IDX_W-1:0] idx);
    return idx >= 3'd3;
  endfunction

endpackage

// File: rtl/idseq_datapath.sv
module idseq_datapath
  import idseq_pkg::*;
#(
  parameter int DWELL  = 16,
  parameter int ACCEPT = 12,
  parameter int LOSS   = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineStb,
  input  logic       palIdFlag,
  input  logic       ntscBurstFlag,
  input  logic       secamLineFlag,
  input  logic [1:0] xtalCfg,
  input  logic [1:0] forceGrp,
  input  logic [1:0] forceXtal,
  input  seqCmd_t    cmd,
  output seqStat_t   stat,
  output logic [1:0] stdSel,
  output logic       xtalSel,
  output logic [1:0] bandSel
);

  localparam int LINE_W = $clog2(DWELL);
  localparam int HIT_W  = $clog2(DWELL + 1);
  localparam int MISS_W = $clog2(LOSS + 1);
  localparam int MASK_W = 1 << IDX_W;

  logic [IDX_W-1:0]  candIdx, nextIdx, firstIdx;
  logic [NCAND-1:0]  okMask;
  logic [MASK_W-1:0] okWide;
  logic [LINE_W-1:0] lineCnt;
  logic [HIT_W-1:0]  hitCnt;
  logic [MISS_W-1:0] missCnt;
  logic              ref44, twoXtal, curFlag, curSecond;
  std_e              curStd;

  assign ref44   = ~xtalCfg[0];
  assign twoXtal = ~xtalCfg[1];

  // permission mask, one entry per candidate
  generate
    for (genvar g = 0; g < NCAND; g++) begin : g_ok
      localparam logic [IDX_W-1:0] GI = IDX_W'(g);
      localparam logic IS_SECAM  = (candStd(GI) == STD_SECAM);
      localparam logic IS_SECOND = candSecond(GI);
      logic stdOk, xtOk;
      if (IS_SECAM) begin : g_sec
        assign stdOk = ref44 && (forceGrp != GRP_PALNTSC);
      end else begin : g_pn
        assign stdOk = (forceGrp != GRP_SECAM);
      end
      if (IS_SECOND) begin : g_x2
        assign xtOk = twoXtal && (forceXtal != XF_REF);
      end else begin : g_x1
        assign xtOk = (forceXtal != XF_SECOND);
      end
      assign okMask[g] = stdOk && xtOk;
    end
  endgenerate

  assign okWide = MASK_W'(okMask);

  // next allowed candidate after the current one, cyclic
  always_comb begin
    logic found;
    found   = 1'b0;
    nextIdx = candIdx;
    for (int k = 1; k <= NCAND; k++) begin
      if (!found && okMask[(int'(candIdx) + k) % NCAND]) begin
        nextIdx = IDX_W'((int'(candIdx) + k) % NCAND);
        found   = 1'b1;
      end
    end
  end

  // lowest allowed candidate, or 0 when none
  always_comb begin
    firstIdx = '0;
    for (int k = NCAND - 1; k >= 0; k--) begin
      if (okMask[k]) firstIdx = IDX_W'(k);
    end
  end

  assign curStd    = candStd(candIdx);
  assign curSecond = candSecond(candIdx);

  always_comb begin
    case (curStd)
      STD_PAL:   curFlag = palIdFlag;
      STD_SECAM: curFlag = secamLineFlag;
      default:   curFlag = ntscBurstFlag;
    endcase
  end

  assign stat.dwellEnd   = (lineCnt == LINE_W'(DWELL - 1));
  assign stat.enoughHits = (int'(hitCnt) + int'(curFlag)) >= ACCEPT;
  assign stat.lossEnd    = !curFlag && (missCnt == MISS_W'(LOSS - 1));
  assign stat.curOk      = okWide[candIdx];
  assign stat.anyOk      = |okMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      candIdx <= '0;
      lineCnt <= '0;
      hitCnt  <= '0;
      missCnt <= '0;
    end else begin
      if (cmd.restart)       candIdx <= firstIdx;
      else if (cmd.stepNext) candIdx <= nextIdx;

      if (cmd.clrCnt) begin
        lineCnt <= '0;
        hitCnt  <= '0;
        missCnt <= '0;
      end else begin
        if (cmd.countLine) begin
          lineCnt <= lineCnt + 1'b1;
          hitCnt  <= hitCnt + HIT_W'(curFlag);
        end
        if (cmd.trackMiss) missCnt <= curFlag ? '0 : missCnt + 1'b1;
      end
    end
  end

  assign stdSel  = curStd;
  assign xtalSel = curSecond;

  always_comb begin
    if (curStd == STD_SECAM)       bandSel = BAND_428;
    else if (!curSecond && ref44)  bandSel = BAND_443;
    else                           bandSel = BAND_358;
  end

  // R3: hits never exceed lines counted in the dwell
  p_hits_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    int'(hitCnt) <= int'(lineCnt) + 1);

  // R5: no SECAM after a strobe without a 4.4 MHz reference
  p_no_secam_r5: assert property (@(posedge clk) disable iff (!rstN)
    (lineStb && xtalCfg[0]) |=> (stdSel != STD_SECAM));

  // R6: single crystal keeps the reference selected
  p_single_ref_r6: assert property (@(posedge clk) disable iff (!rstN)
    (lineStb && xtalCfg[1]) |=> !xtalSel);

  // R7: PAL/NTSC force excludes SECAM
  p_force_pn_r7: assert property (@(posedge clk) disable iff (!rstN)
    (lineStb && forceGrp == GRP_PALNTSC) |=> (stdSel != STD_SECAM));

  // R14: candidate frozen between strobes
  p_hold_idx_r14: assert property (@(posedge clk) disable iff (!rstN)
    !lineStb |=> $stable(candIdx));

endmodule

// File: rtl/idseq_control.sv
module idseq_control
  import idseq_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     lineStb,
  input  seqStat_t stat,
  output seqCmd_t  cmd,
  output logic     locked
);

  seqState_e state, stateNext;

  always_comb begin
    cmd       = '0;
    stateNext = state;
    if (lineStb) begin
      case (state)
        ST_SEARCH: begin
          if (!stat.anyOk) begin
            cmd.restart = 1'b1;
            cmd.clrCnt  = 1'b1;
          end else if (!stat.curOk) begin
            cmd.stepNext = 1'b1;
            cmd.clrCnt   = 1'b1;
          end else if (stat.dwellEnd) begin
            cmd.clrCnt = 1'b1;
            if (stat.enoughHits) stateNext = ST_LOCKED;
            else                 cmd.stepNext = 1'b1;
          end else begin
            cmd.countLine = 1'b1;
          end
        end
        default: begin
          if (!stat.curOk || stat.lossEnd) begin
            cmd.restart = 1'b1;
            cmd.clrCnt  = 1'b1;
            stateNext   = ST_SEARCH;
          end else begin
            cmd.trackMiss = 1'b1;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_SEARCH;
    else       state <= stateNext;
  end

  assign locked = (state == ST_LOCKED);

  // R3: lock only at the end of a successful dwell
  p_lock_dwell_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(locked) |-> $past(lineStb && stat.dwellEnd && stat.enoughHits));

  // R10: release only on a miss run or a disallowed lock (R13)
  p_release_r10: assert property (@(posedge clk) disable iff (!rstN)
    $fell(locked) |-> $past(lineStb && (stat.lossEnd || !stat.curOk)));

  // R14: lock state frozen between strobes
  p_hold_lock_r14: assert property (@(posedge clk) disable iff (!rstN)
    !lineStb |=> $stable(locked));

endmodule

// File: rtl/colour_id_seq.sv
module colour_id_seq
  import idseq_pkg::*;
#(
  parameter int DWELL  = 16,
  parameter int ACCEPT = 12,
  parameter int LOSS   = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       lineStb,
  input  logic       palIdFlag,
  input  logic       ntscBurstFlag,
  input  logic       secamLineFlag,
  input  logic [1:0] xtalCfg,
  input  logic [1:0] forceGrp,
  input  logic [1:0] forceXtal,
  output logic [1:0] stdSel,
  output logic       xtalSel,
  output logic [1:0] bandSel,
  output logic       colourKill,
  output logic       locked,
  output logic [3:0] statusWord
);

  seqCmd_t  cmd;
  seqStat_t stat;

  idseq_datapath #(.DWELL(DWELL), .ACCEPT(ACCEPT), .LOSS(LOSS)) u_dp (
    .clk(clk), .rstN(rstN), .lineStb(lineStb),
    .palIdFlag(palIdFlag), .ntscBurstFlag(ntscBurstFlag), .secamLineFlag(secamLineFlag),
    .xtalCfg(xtalCfg), .forceGrp(forceGrp), .forceXtal(forceXtal),
    .cmd(cmd), .stat(stat),
    .stdSel(stdSel), .xtalSel(xtalSel), .bandSel(bandSel)
  );

  idseq_control u_ctl (
    .clk(clk), .rstN(rstN), .lineStb(lineStb),
    .stat(stat), .cmd(cmd), .locked(locked)
  );

  assign colourKill = ~locked;
  assign statusWord = {colourKill, xtalSel, stdSel};

  // R11: killer and lock never agree
  p_kill_r11: assert property (@(posedge clk) disable iff (!rstN)
    colourKill != locked);

endmodule

// File: tb/colour_id_seq_tb.sv
`timescale 1ns/1ps
module colour_id_seq_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lineStb = 1'b0;
  logic palIdFlag = 1'b0, ntscBurstFlag = 1'b0, secamLineFlag = 1'b0;
  logic [1:0] xtalCfg = 2'b00, forceGrp = 2'b00, forceXtal = 2'b00;
  logic [1:0] stdSel, bandSel;
  logic xtalSel, colourKill, locked;
  logic [3:0] statusWord;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  // bench-side model state
  int mIdx, mLines, mHits, mMiss;
  bit mLocked;

  always #2.5 clk = ~clk;

  colour_id_seq u_dut (
    .clk(clk), .rstN(rstN), .lineStb(lineStb),
    .palIdFlag(palIdFlag), .ntscBurstFlag(ntscBurstFlag), .secamLineFlag(secamLineFlag),
    .xtalCfg(xtalCfg), .forceGrp(forceGrp), .forceXtal(forceXtal),
    .stdSel(stdSel), .xtalSel(xtalSel), .bandSel(bandSel),
    .colourKill(colourKill), .locked(locked), .statusWord(statusWord)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d cycles expected<=150000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  // candidate table from R4: std 0 PAL, 1 NTSC, 2 SECAM
  function automatic int bStd(int i);
    case (i)
      0: return 0;
      1: return 2;
      2: return 1;
      3: return 0;
      default: return 1;
    endcase
  endfunction

  function automatic bit bSecond(int i);
    return i >= 3;
  endfunction

  function automatic bit bOk(int i);
    bit s, x;
    if (bStd(i) == 2) s = (xtalCfg[0] == 1'b0) && (forceGrp != 2'b10);
    else              s = (forceGrp != 2'b01);
    if (bSecond(i))   x = (xtalCfg[1] == 1'b0) && (forceXtal != 2'b01);
    else              x = (forceXtal != 2'b10);
    return s && x;
  endfunction

  function automatic int bBand(int i);
    if (bStd(i) == 2) return 1;
    if (!bSecond(i) && xtalCfg[0] == 1'b0) return 2;
    return 0;
  endfunction

  function automatic int bNext(int i);
    for (int k = 1; k <= 5; k++) if (bOk((i + k) % 5)) return (i + k) % 5;
    return i;
  endfunction

  function automatic int bFirst();
    for (int k = 0; k < 5; k++) if (bOk(k)) return k;
    return 0;
  endfunction

  function automatic bit bAny();
    for (int k = 0; k < 5; k++) if (bOk(k)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic logic [7:0] expVec();
    logic [1:0] s;
    s = 2'(bStd(mIdx));
    return {!mLocked, bSecond(mIdx), s, 2'(bBand(mIdx)), mLocked, 1'b0};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkOutputs(input string tag);
    logic [7:0] act, exp;
    act = {colourKill, xtalSel, stdSel, bandSel, locked, 1'b0};
    exp = expVec();
    check(act == exp, tag, 16'(act), 16'(exp));
    // R2: status layout
    check(statusWord == {colourKill, xtalSel, stdSel}, "R2 status layout",
          16'(statusWord), 16'({colourKill, xtalSel, stdSel}));
  endtask

  task automatic resetAll();
    @(negedge clk);
    rstN = 1'b0; lineStb = 1'b0;
    palIdFlag = 1'b0; ntscBurstFlag = 1'b0; secamLineFlag = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    mIdx = 0; mLines = 0; mHits = 0; mMiss = 0; mLocked = 1'b0;
  endtask

  task automatic modelStep(input bit p, input bit n, input bit s);
    bit f;
    case (bStd(mIdx))
      0: f = p;
      2: f = s;
      default: f = n;
    endcase
    if (!mLocked) begin
      if (!bAny()) begin
        mIdx = 0; mLines = 0; mHits = 0; mMiss = 0;
      end else if (!bOk(mIdx)) begin
        mIdx = bNext(mIdx); mLines = 0; mHits = 0; mMiss = 0;
      end else if (mLines == 15) begin
        if (mHits + f >= 12) mLocked = 1'b1;
        else mIdx = bNext(mIdx);
        mLines = 0; mHits = 0; mMiss = 0;
      end else begin
        mLines++; mHits += f;
      end
    end else begin
      if (!bOk(mIdx) || (!f && mMiss == 7)) begin
        mLocked = 1'b0; mIdx = bFirst(); mLines = 0; mHits = 0; mMiss = 0;
      end else begin
        mMiss = f ? 0 : mMiss + 1;
      end
    end
  endtask

  task automatic doLine(input bit p, input bit n, input bit s, input string tag);
    @(negedge clk);
    lineStb = 1'b1; palIdFlag = p; ntscBurstFlag = n; secamLineFlag = s;
    @(negedge clk);
    lineStb = 1'b0; palIdFlag = 1'b0; ntscBurstFlag = 1'b0; secamLineFlag = 1'b0;
    modelStep(p, n, s);
    checkOutputs(tag);
  endtask

  initial begin
    // R1: reset state
    xtalCfg = 2'b00; forceGrp = 2'b00; forceXtal = 2'b00;
    resetAll();
    @(negedge clk);
    check({colourKill, locked, xtalSel, stdSel, bandSel} == 7'b1000010, "R1 reset state",
          16'({colourKill, locked, xtalSel, stdSel, bandSel}), 16'(7'b1000010));

    // R4 R5 R6 R7 R8 R12: sweep of every fit/force combination with idle flags
    for (int c = 0; c < 64; c++) begin
      xtalCfg = c[1:0]; forceGrp = c[3:2]; forceXtal = c[5:4];
      resetAll();
      for (int l = 0; l < 90; l++) doLine(1'b0, 1'b0, 1'b0, "R4 R5 R6 R7 R8 sweep");
    end

    xtalCfg = 2'b00; forceGrp = 2'b00; forceXtal = 2'b00;

    // R14 then R3: flags without strobes, then 11 hits in a dwell
    resetAll();
    @(negedge clk); palIdFlag = 1'b1;
    repeat (20) @(negedge clk);
    palIdFlag = 1'b0;
    for (int l = 0; l < 16; l++) doLine(l < 11, 1'b0, 1'b0, "R14 R3 eleven hits");
    check(!locked && stdSel == 2'b10, "R3 no lock with 11 hits",
          16'({locked, stdSel}), 16'({1'b0, 2'b10}));

    // R3 R11 R12: 12 hits locks PAL at 4.43 MHz
    resetAll();
    for (int l = 0; l < 16; l++) doLine(l >= 4, 1'b0, 1'b0, "R3 twelve hits");
    check(locked && !colourKill && stdSel == 2'b00 && bandSel == 2'b10, "R3 R11 R12 PAL lock",
          16'({locked, colourKill, stdSel, bandSel}), 16'({1'b1, 1'b0, 2'b00, 2'b10}));

    // R10: 7 misses hold, a hit clears, 8 misses release
    for (int l = 0; l < 7; l++) doLine(1'b0, 1'b0, 1'b0, "R10 seven misses");
    check(locked, "R10 held after 7 misses", 16'(locked), 16'd1);
    doLine(1'b1, 1'b0, 1'b0, "R10 hit clears run");
    for (int l = 0; l < 7; l++) doLine(1'b0, 1'b0, 1'b0, "R10 seven misses again");
    check(locked, "R10 run restarted by hit", 16'(locked), 16'd1);
    doLine(1'b0, 1'b0, 1'b0, "R10 eighth miss");
    check(!locked && colourKill && stdSel == 2'b00, "R10 release to first candidate",
          16'({locked, colourKill, stdSel}), 16'({1'b0, 1'b1, 2'b00}));

    // R9: PAL and SECAM flags together lock PAL
    resetAll();
    for (int l = 0; l < 16; l++) doLine(1'b1, 1'b0, 1'b1, "R9 PAL priority");
    check(locked && stdSel == 2'b00, "R9 PAL wins", 16'({locked, stdSel}), 16'({1'b1, 2'b00}));

    // R9 R12: SECAM flags alone lock SECAM at 4.28 MHz
    resetAll();
    for (int l = 0; l < 32; l++) doLine(1'b0, 1'b1 & 1'b0, 1'b1, "R9 SECAM search");
    check(locked && stdSel == 2'b10 && bandSel == 2'b01, "R9 R12 SECAM lock",
          16'({locked, stdSel, bandSel}), 16'({1'b1, 2'b10, 2'b01}));

    // R13: force change acts only at next strobe and drops the lock
    @(negedge clk); forceGrp = 2'b10;
    repeat (5) @(negedge clk);
    check(locked, "R13 lock kept until strobe", 16'(locked), 16'd1);
    doLine(1'b0, 1'b0, 1'b1, "R13 force drop");
    check(!locked && stdSel == 2'b00, "R13 lock dropped", 16'({locked, stdSel}), 16'({1'b0, 2'b00}));
    forceGrp = 2'b00;

    // R6 R8: single crystal forced to second -> idle on PAL/reference
    xtalCfg = 2'b10; forceXtal = 2'b10;
    resetAll();
    for (int l = 0; l < 20; l++) doLine(1'b1, 1'b1, 1'b1, "R6 R8 nothing allowed");
    check(!xtalSel && colourKill && stdSel == 2'b00, "R6 R8 idle state",
          16'({xtalSel, colourKill, stdSel}), 16'({1'b0, 1'b1, 2'b00}));

    // R8 R12: NTSC on second crystal at 3.58 MHz
    xtalCfg = 2'b00; forceXtal = 2'b10;
    resetAll();
    for (int l = 0; l < 17; l++) doLine(1'b0, 1'b0, 1'b0, "R8 PAL second fails");
    for (int l = 0; l < 16; l++) doLine(1'b0, 1'b1, 1'b0, "R8 NTSC second");
    check(locked && xtalSel && stdSel == 2'b01 && bandSel == 2'b00, "R8 R12 NTSC second lock",
          16'({locked, xtalSel, stdSel, bandSel}), 16'({1'b1, 1'b1, 2'b01, 2'b00}));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule